// File: doc/BRIEF.md
# Oversampled Bit Clock and Data Recovery

This block turns a hard-limited serial receive stream into retimed bits. The raw line is sampled once per pulse of a sample enable. The enable is expected at 29 pulses per bit period; the divider that makes it lies outside the block. Each sample first passes a three-sample majority filter, which removes isolated one-sample spikes. Transitions of the filtered stream then steer a modulo-29 phase counter. When that counter reaches its mid-bit index, the block emits one recovered bit together with a single-cycle valid strobe, which can load a receive FIFO directly.

The tracking loop gain is chosen by a two-bit mode input. Fast mode snaps the phase onto every edge, so it settles within one transition. Slow mode nudges the phase by at most one sample per edge, which gives better noise immunity but needs more accurate bit timing. Automatic mode runs fast until a lock flag rises, runs slow while locked, and returns to fast when lock is lost. The lock flag is driven by counting consecutive edges that fall inside or outside a ±2-sample window around the expected edge position.

The recovered-bit output is a valid-only stream with no ready signal. The block cannot be back-pressured, so the consumer must take `out_data` in every cycle in which `out_valid` is high. Bits arrive no faster than one per 15 sample enables.

Top module: `cdr_bit_recover`

## Requirements
- R1: While `rst_n` is low and after reset release, `out_valid`, `out_data` and `locked` are 0, and the phase index is 0.
- R2: Each sample is filtered as the majority of itself and the two previous samples. An isolated one-sample flip inside a bit therefore creates no edge and does not change the recovered bit.
- R3: `out_valid` is a single-cycle pulse in the clock cycle after the sample enable on which the phase index becomes 14. With no filtered edges, consecutive pulses are exactly 29 sample enables apart.
- R4: With each pulse, `out_data` carries the filtered value of the sample whose index became 14.
- R5: In mode 0 (fast), a sample whose filtered value differs from the previous filtered value is given phase index 0.
- R6: In mode 1 (slow), such an edge sample takes its nominal index n, with the index moved one step toward 0. If n is 1..14 the index becomes n−1. If n is 15..27 it becomes n+1. If n is 0 or 28 it becomes 0.
- R7: An edge is in-window when its nominal index n satisfies n ≤ 2 or n ≥ 27. `locked` rises when 8 consecutive edges are in-window. An out-of-window edge restarts this count.
- R8: `locked` falls when 4 consecutive edges are out-of-window. An in-window edge restarts this count.
- R9: In mode 2 (automatic), edges are handled as in fast mode while `locked` is 0 and as in slow mode while `locked` is 1. The value of `locked` used is the one before the edge is counted.
- R10: Mode 3 behaves the same as mode 2.
- R11: In a cycle where `samp_en` is low, no state changes. In the following cycle `out_valid` is 0 and `locked` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_en | input | 1 | Oversampling enable, 29 pulses per bit period |
| rx_raw | input | 1 | Hard-limited receive data, sampled when `samp_en` is high |
| mode | input | 2 | Tracking mode: 0 fast, 1 slow, 2 or 3 automatic |
| out_valid | output | 1 | Recovered-bit strobe, one cycle, no back-pressure |
| out_data | output | 1 | Recovered bit, valid while `out_valid` is high |
| locked | output | 1 | Phase lock indication |

## Verification
A wrong phase index or a wrong correction step shows up as a strobe that arrives one or more sample enables early or late. The bench sees this at the very next recovered bit, because it compares every strobe cycle against a sample-level model of the requirements. A fault in the filter shows up as a flipped `out_data` bit, or as a spurious realignment in the bit after a one-sample glitch. A mistake in the lock counters shows up as `locked` changing on the wrong edge, and in automatic mode it also shifts the strobe timing from that edge onward. Mid-bit phase jumps of 10 samples are injected to drive the unlock path, and the bench then waits for lock to return.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
  typedef enum logic [1:0] {
    TRK_FAST     = 2'd0,
    TRK_SLOW     = 2'd1,
    TRK_AUTO     = 2'd2,
    TRK_AUTO_ALT = 2'd3
  } trk_mode_e;
endpackage

// File: rtl/cdr_maj_filter.sv
module cdr_maj_filter #(
  parameter int TAPS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_en,
  input  logic rx_raw,
  output logic filt_now,
  output logic edge_hit
);
  localparam int HW = TAPS - 1;

  logic [HW-1:0] hist;
  logic [TAPS-1:0] win;
  logic filt_q;

  assign win      = {hist, rx_raw};
  assign filt_now = ($countones(win) > (TAPS / 2));
  assign edge_hit = samp_en & (filt_now ^ filt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist   <= '0;
      filt_q <= 1'b0;
    end else if (samp_en) begin
      hist   <= win[HW-1:0];
      filt_q <= filt_now;
    end
  end
endmodule

// File: rtl/cdr_phase_track.sv
module cdr_phase_track #(
  parameter int OSR = 29,
  parameter int MID = 14,
  parameter int WIN = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     samp_en,
  input  logic                     edge_hit,
  input  logic                     use_slow,
  input  logic                     filt_now,
  output logic [$clog2(OSR)-1:0]   phase_idx,
  output logic                     in_win,
  output logic                     bit_vld,
  output logic                     bit_dat
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST  = CW'(OSR - 1);
  localparam logic [CW-1:0] MIDV  = CW'(MID);
  localparam logic [CW-1:0] WLO   = CW'(WIN);
  localparam logic [CW-1:0] WHI   = CW'(OSR - WIN);

  logic [CW-1:0] nxt, slow_fix, idx_d;

  always_comb begin
    nxt = (phase_idx == LAST) ? '0 : phase_idx + 1'b1;
    in_win = (nxt <= WLO) || (nxt >= WHI);
    if (nxt == '0 || nxt == LAST) slow_fix = '0;
    else if (nxt <= MIDV)         slow_fix = nxt - 1'b1;
    else                          slow_fix = nxt + 1'b1;
    if (edge_hit) idx_d = use_slow ? slow_fix : '0;
    else          idx_d = nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_idx <= '0;
      bit_vld   <= 1'b0;
      bit_dat   <= 1'b0;
    end else begin
      bit_vld <= samp_en && (idx_d == MIDV);
      if (samp_en) begin
        phase_idx <= idx_d;
        if (idx_d == MIDV) bit_dat <= filt_now;
      end
    end
  end
endmodule

// File: rtl/cdr_lock_mon.sv
module cdr_lock_mon #(
  parameter int LOCK_N   = 8,
  parameter int UNLOCK_N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_hit,
  input  logic in_win,
  output logic locked
);
  localparam int LW = $clog2(LOCK_N + 1);
  localparam int UW = $clog2(UNLOCK_N + 1);

  logic [LW-1:0] good_run;
  logic [UW-1:0] bad_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_run <= '0;
      bad_run  <= '0;
      locked   <= 1'b0;
    end else if (edge_hit) begin
      if (in_win) begin
        bad_run <= '0;
        if (good_run != LW'(LOCK_N)) good_run <= good_run + 1'b1;
        if (good_run == LW'(LOCK_N - 1)) locked <= 1'b1;
      end else begin
        good_run <= '0;
        if (bad_run != UW'(UNLOCK_N)) bad_run <= bad_run + 1'b1;
        if (bad_run == UW'(UNLOCK_N - 1)) locked <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cdr_bit_recover.sv
module cdr_bit_recover #(
  parameter int OSR      = 29,
  parameter int MID      = 14,
  parameter int WIN      = 2,
  parameter int TAPS     = 3,
  parameter int LOCK_N   = 8,
  parameter int UNLOCK_N = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       samp_en,
  input  logic       rx_raw,
  input  logic [1:0] mode,
  output logic       out_valid,
  output logic       out_data,
  output logic       locked
);
  import cdr_pkg::*;
  localparam int CW = $clog2(OSR);

  logic            filt_now, edge_hit, in_win, use_slow;
  logic [CW-1:0]   phase_idx;
  trk_mode_e       mode_e;

  assign mode_e   = trk_mode_e'(mode);
  assign use_slow = (mode_e == TRK_SLOW) ||
                    (((mode_e == TRK_AUTO) || (mode_e == TRK_AUTO_ALT)) && locked);

  cdr_maj_filter #(.TAPS(TAPS)) u_filt (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rx_raw(rx_raw),
    .filt_now(filt_now), .edge_hit(edge_hit)
  );

  cdr_phase_track #(.OSR(OSR), .MID(MID), .WIN(WIN)) u_track (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .edge_hit(edge_hit),
    .use_slow(use_slow), .filt_now(filt_now), .phase_idx(phase_idx),
    .in_win(in_win), .bit_vld(out_valid), .bit_dat(out_data)
  );

  cdr_lock_mon #(.LOCK_N(LOCK_N), .UNLOCK_N(UNLOCK_N)) u_lock (
    .clk(clk), .rst_n(rst_n), .edge_hit(edge_hit), .in_win(in_win),
    .locked(locked)
  );
endmodule

// File: rtl/cdr_bit_recover_chk.sv
module cdr_bit_recover_chk #(
  parameter int OSR = 29,
  parameter int MID = 14
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   samp_en,
  input logic [1:0]             mode,
  input logic                   out_valid,
  input logic                   locked,
  input logic                   edge_hit,
  input logic [$clog2(OSR)-1:0] phase_idx
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R3
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(phase_idx) < OSR); // R3
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_en |=> !out_valid); // R11
  AST_IDLE_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_en |=> $stable(locked)); // R11
  AST_FAST_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit && mode == 2'd0) |=> phase_idx == '0); // R5
  AST_SLOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit && mode == 2'd1 && int'(phase_idx) < MID) |=> phase_idx == $past(phase_idx)); // R6
endmodule

bind cdr_bit_recover cdr_bit_recover_chk #(.OSR(OSR), .MID(MID)) u_chk (
  .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .mode(mode),
  .out_valid(out_valid), .locked(locked), .edge_hit(edge_hit),
  .phase_idx(phase_idx)
);

// File: tb/cdr_bit_recover_test.sv
`timescale 1ns/1ps
module cdr_bit_recover_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       samp_en = 1'b0;
  logic       rx_raw = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       out_valid, out_data, locked;

  always #4 clk = ~clk;

  cdr_bit_recover uut (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rx_raw(rx_raw),
    .mode(mode), .out_valid(out_valid), .out_data(out_data), .locked(locked)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  bit chk_bits = 1'b0, chk_gap = 1'b0, cur_bit = 1'b0;
  int n_samp = 0, last_strobe = -1;

  // requirement model state
  bit m_h1, m_h0, m_filt, m_lock, m_vld, m_dat;
  int m_cnt, m_in, m_out;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string mtag();
    case (mode)
      2'd0: return "R3 R5 strobe";
      2'd1: return "R3 R6 strobe";
      2'd2: return "R3 R9 strobe";
      default: return "R3 R10 strobe";
    endcase
  endfunction

  function automatic int slow_step(input int n);
    if (n == 0 || n == 28) return 0;
    if (n <= 14) return n - 1;
    return n + 1;
  endfunction

  task automatic model_reset();
    m_h1 = 0; m_h0 = 0; m_filt = 0; m_lock = 0; m_vld = 0; m_dat = 0;
    m_cnt = 0; m_in = 0; m_out = 0;
  endtask

  task automatic model_step(input bit v);
    bit maj, e, slow, iw;
    int nxt;
    maj = (int'(m_h1) + int'(m_h0) + int'(v)) >= 2;
    e = (maj != m_filt);
    m_h1 = m_h0; m_h0 = v; m_filt = maj;
    nxt = (m_cnt == 28) ? 0 : m_cnt + 1;
    slow = (mode == 2'd1) || (mode >= 2'd2 && m_lock);
    if (e) begin
      iw = (nxt <= 2) || (nxt >= 27);
      m_cnt = slow ? slow_step(nxt) : 0;
      if (iw) begin
        m_out = 0;
        if (m_in < 8) m_in++;
        if (m_in == 8) m_lock = 1;
      end else begin
        m_in = 0;
        if (m_out < 4) m_out++;
        if (m_out == 4) m_lock = 0;
      end
    end else begin
      m_cnt = nxt;
    end
    m_vld = (m_cnt == 14);
    m_dat = maj;
  endtask

  task automatic tick(input bit v);
    @(negedge clk);
    check(out_valid == 1'b0, "R11 idle strobe", out_valid, 0);
    check(locked == m_lock, "R11 idle lock", locked, m_lock);
    samp_en = 1'b1; rx_raw = v;
    model_step(v);
    n_samp++;
    @(negedge clk);
    samp_en = 1'b0;
    check(out_valid == m_vld, mtag(), out_valid, m_vld);
    if (m_vld) check(out_data == m_dat, "R4 data", out_data, m_dat);
    check(locked == m_lock, "R7 R8 lock", locked, m_lock);
    if (chk_bits && out_valid) check(out_data == cur_bit, "R2 glitch-free data", out_data, cur_bit);
    if (out_valid) begin
      if (chk_gap && last_strobe >= 0) check(n_samp - last_strobe == 29, "R3 interval", n_samp - last_strobe, 29);
      last_strobe = n_samp;
    end
  endtask

  task automatic send_bit(input bit b, input int len, input int gpos);
    cur_bit = b;
    for (int k = 0; k < len; k++) tick((k == gpos) ? ~b : b);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; samp_en = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R1 reset strobe", out_valid, 0);
    check(out_data == 0, "R1 reset data", out_data, 0);
    check(locked == 0, "R1 reset lock", locked, 0);
    rst_n = 1'b1;
  endtask

  task automatic alt_bits(input int n);
    for (int i = 0; i < n; i++) send_bit(~cur_bit, 29, -1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'h0C0FFEE5));
    model_reset();
    do_reset();

    // fast mode, clean bits with isolated glitches
    mode = 2'd0; cur_bit = 0;
    alt_bits(4);
    chk_bits = 1;
    for (int i = 0; i < 20; i++)
      send_bit(1'($urandom_range(0, 1)), 29, int'($urandom_range(3, 25)));
    chk_bits = 0;

    // steady level: strobes every 29 samples
    send_bit(~cur_bit, 29, -1);
    chk_gap = 1; last_strobe = -1;
    send_bit(cur_bit, 29 * 5, -1);
    chk_gap = 0;

    // automatic mode: acquire, lose on jump, reacquire
    do_reset(); mode = 2'd2; cur_bit = 0;
    alt_bits(4);
    check(locked == 0, "R7 not yet locked", locked, 0);
    alt_bits(8);
    check(locked == 1, "R7 R9 locked", locked, 1);
    send_bit(~cur_bit, 39, -1);
    alt_bits(6);
    check(locked == 0, "R8 R9 unlock after jump", locked, 0);
    alt_bits(12);
    check(locked == 1, "R9 relock", locked, 1);

    // slow mode with a phase step
    do_reset(); mode = 2'd1; cur_bit = 0;
    alt_bits(20);
    send_bit(~cur_bit, 34, -1);
    alt_bits(20);
    check(locked == 1, "R6 R7 slow converges", locked, 1);

    // alternate automatic encoding
    do_reset(); mode = 2'd3; cur_bit = 0;
    alt_bits(12);
    check(locked == 1, "R10 locked", locked, 1);

    // random streams in every mode
    for (int r = 0; r < 8; r++) begin
      mode = 2'(r % 4);
      for (int i = 0; i < 30; i++) begin
        int len;
        int g;
        len = 28 + int'($urandom_range(0, 2));
        if ($urandom_range(0, 19) == 0) len += 8;
        g = ($urandom_range(0, 3) == 0) ? int'($urandom_range(3, 25)) : -1;
        send_bit(1'($urandom_range(0, 1)), len, g);
      end
    end

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule